// File: doc/BRIEF.md
# Oscillator Band Select Timer

This block times the automatic oscillator band selection interval of a frequency synthesizer. A selection interval begins when reset is released and again every time the main divider register (register 0) is written. The interval is measured in band-select clock periods. A band-select period is a programmable number of reference counter output pulses. The interval lasts ten such periods, so its length is ten times the divide ratio, counted in reference pulses.

The reference counter output reaches the block as a single-cycle enable pulse in the system clock domain. The 8-bit divide ratio comes from a configuration field and is captured when an interval starts. While the interval runs, the block holds a control that disconnects the tuning voltage from the loop filter and ties it to an internal reference. When the interval ends, it releases that control so that normal loop operation resumes, and it emits a one-cycle completion pulse.

Top module: `osc_band_timer`

## Requirements
- R1: While `rst` is high, `busy` and `tune_hold` read 1 and `done` reads 0. An interval then runs from reset release, using the `div_ratio` value present during reset.
- R2: With an effective ratio D (1 to 255), `busy` stays 1 for exactly 10*D pulses of `ref_tick`. It reads 0 from the clock edge that accepts the 10*D-th pulse.
- R3: A `div_ratio` of 0 behaves exactly like a ratio of 1, so the interval is 10 pulses.
- R4: `tune_hold` equals `busy` in every cycle.
- R5: `done` is 1 for exactly one cycle, in the cycle in which `busy` first reads 0 at the end of an interval. It is 0 at all other times.
- R6: A `r0_write` pulse during an interval restarts the interval from zero. The full 10*D pulses are counted again from that point.
- R7: If `r0_write` arrives in the same cycle as the final `ref_tick` pulse, the restart wins: `busy` stays 1, no `done` pulse is produced, and a full new interval follows.
- R8: While the block is idle, `ref_tick` pulses have no effect: `busy` and `done` stay 0, and the next interval still lasts exactly 10*D pulses.
- R9: `div_ratio` is sampled when an interval starts. Changing it during the interval does not change that interval's length.
- R10: A `r0_write` pulse while the block is idle starts a new interval. `busy` reads 1 from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts an interval on release |
| ref_tick | input | 1 | One-cycle pulse from the reference counter output |
| r0_write | input | 1 | One-cycle pulse marking a write to register 0 |
| div_ratio | input | 8 | Band-select divide ratio (0 treated as 1) |
| busy | output | 1 | Selection interval in progress |
| tune_hold | output | 1 | Tuning voltage disconnected from the loop filter and tied to the internal reference |
| done | output | 1 | One-cycle pulse when an interval completes |

## Verification
Two events can fall in the same cycle: the completion of an interval and a restart request. The bench provokes this by driving `r0_write` and the final `ref_tick` of an interval on the same clock edge. The correct outcome is that `busy` stays high, no `done` pulse appears, and a complete fresh interval of exactly 10*D pulses follows. Every divide ratio from 0 to 20, plus 255, is also run through a full interval, and the expected length is computed arithmetically.

// File: rtl/obt_pkg.sv
package obt_pkg;

    // number of band-select clock periods per selection interval
    localparam int unsigned SEL_PERIODS = 10;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEL  = 1'b1
    } sel_state_e;

    typedef struct packed {
        logic busy;
        logic done;
    } sel_status_t;

endpackage

// File: rtl/obt_prescaler.sv
module obt_prescaler #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             enable,
    input  logic             tick,
    input  logic [DIV_W-1:0] ratio,
    output logic             band_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap      = (cnt_q == ratio - 1'b1);
    assign band_tick = enable && tick && wrap && !clear;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (enable && tick) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    // R2
    cnt_below_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio != '0) |-> (cnt_q < ratio));

endmodule

// File: rtl/obt_interval.sv
module obt_interval
    import obt_pkg::*;
#(
    parameter int unsigned PERIODS = SEL_PERIODS
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        band_tick,
    output sel_status_t status
);
    localparam int unsigned CNT_W = (PERIODS > 1) ? $clog2(PERIODS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIODS - 1);

    sel_state_e       state_q;
    logic [CNT_W-1:0] cyc_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SEL;
            cyc_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                state_q <= ST_SEL;
                cyc_q   <= '0;
            end else if (state_q == ST_SEL && band_tick) begin
                if (cyc_q == LAST) begin
                    state_q <= ST_IDLE;
                    cyc_q   <= '0;
                    done_q  <= 1'b1;
                end else begin
                    cyc_q <= cyc_q + 1'b1;
                end
            end
        end
    end

    assign status.busy = (state_q == ST_SEL);
    assign status.done = done_q;

    // R2
    cyc_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_q <= LAST);

    // R8
    idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (cyc_q == '0));

endmodule

// File: rtl/osc_band_timer.sv
module osc_band_timer
    import obt_pkg::*;
#(
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned PERIODS = SEL_PERIODS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             r0_write,
    input  logic [DIV_W-1:0] div_ratio,
    output logic             busy,
    output logic             tune_hold,
    output logic             done
);
    logic [DIV_W-1:0] ratio_q;
    logic [DIV_W-1:0] ratio_eff;
    logic             band_tick;
    sel_status_t      status;

    assign ratio_eff = (div_ratio == '0) ? DIV_W'(1) : div_ratio;

    always_ff @(posedge clk) begin
        if (rst || r0_write) begin
            ratio_q <= ratio_eff;
        end
    end

    obt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .clear     (r0_write),
        .enable    (status.busy),
        .tick      (ref_tick),
        .ratio     (ratio_q),
        .band_tick (band_tick)
    );

    obt_interval #(.PERIODS(PERIODS)) u_int (
        .clk       (clk),
        .rst       (rst),
        .start     (r0_write),
        .band_tick (band_tick),
        .status    (status)
    );

    assign busy      = status.busy;
    assign tune_hold = status.busy;
    assign done      = status.done;

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    done_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R6
    restart_busy_chk: assert property (@(posedge clk) disable iff (rst)
        r0_write |=> (busy && !done));

    // R8
    idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !r0_write) |=> (!busy && !done));

endmodule

// File: tb/osc_band_timer_test.sv
module osc_band_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0;
    logic       r0_write = 1'b0;
    logic [7:0] div_ratio = 8'd0;
    logic       busy, tune_hold, done;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    osc_band_timer uut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .r0_write(r0_write),
        .div_ratio(div_ratio), .busy(busy), .tune_hold(tune_hold), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) ref_tick = 1'b1;
        @(negedge clk) ref_tick = 1'b0;
    endtask

    task automatic write_r0(input logic [7:0] d);
        @(negedge clk) begin div_ratio = d; r0_write = 1'b1; end
        @(negedge clk) r0_write = 1'b0;
        check("R10 busy after write", busy, 1);
        check("R6 no done after write", done, 0);
    endtask

    // run a whole interval of total pulses, checking every step
    task automatic run_full(input int total, input string req);
        for (int n = 1; n <= total; n++) begin
            pulse_tick();
            check(req, busy, (n < total) ? 1 : 0);
            check("R4 tune_hold", tune_hold, busy);
            check("R5 done timing", done, (n == total) ? 1 : 0);
        end
        @(negedge clk);
        check("R5 done one cycle", done, 0);
        check(req, busy, 0);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state and interval from reset release
        div_ratio = 8'd3;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy, 1);
        check("R1 tune_hold in reset", tune_hold, 1);
        check("R1 done in reset", done, 0);
        rst = 1'b0;
        div_ratio = 8'd7;  // R9: change after capture has no effect
        run_full(30, "R1 interval from reset");

        // R2 / R3: sweep of ratios
        for (int d = 0; d <= 20; d++) begin
            write_r0(8'(d));
            run_full(10 * ((d == 0) ? 1 : d), (d == 0) ? "R3 ratio zero" : "R2 length");
        end
        write_r0(8'd255);
        run_full(2550, "R2 length max");

        // R8: idle pulses ignored
        for (int k = 0; k < 7; k++) begin
            pulse_tick();
            check("R8 idle busy", busy, 0);
            check("R8 idle done", done, 0);
        end
        write_r0(8'd2);
        run_full(20, "R8 length after idle pulses");

        // R6: restart mid-interval
        write_r0(8'd3);
        for (int k = 0; k < 17; k++) pulse_tick();
        check("R6 still busy", busy, 1);
        write_r0(8'd3);
        run_full(30, "R6 restart length");

        // R7: restart coincident with final pulse
        write_r0(8'd2);
        for (int k = 0; k < 19; k++) pulse_tick();
        @(negedge clk) begin ref_tick = 1'b1; r0_write = 1'b1; end
        @(negedge clk) begin ref_tick = 1'b0; r0_write = 1'b0; end
        check("R7 busy kept", busy, 1);
        check("R7 no done", done, 0);
        @(negedge clk);
        check("R7 no done later", done, 0);
        run_full(20, "R7 fresh interval");

        // R9: ratio change mid-interval ignored
        write_r0(8'd4);
        div_ratio = 8'd1;
        run_full(40, "R9 latched ratio");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule